// File: doc/BRIEF.md
# Three-Stage Pipelined 8-bit Processor Core

This core runs a small two-operand instruction set on 8-bit unsigned data. Three stages work on different instructions in every clock. Fetch reads 17-bit instruction words from a 1K-word instruction memory into a four-entry queue. Execute takes the oldest queued word, decodes it and acts on it. Write-result commits a pending store to the 1K-byte data memory one cycle after the store executed. The store's address and data are held in dedicated registers until then.

Both memories have a synchronous port: an address presented with its enable in one cycle returns data in the next. A taken branch or a program-counter load flushes the queue and drops any fetch in flight, and fetch restarts at the new address. A load from memory holds execute for one cycle while its data returns. A load that follows a store also waits one cycle, so the data port never reads and writes in the same cycle.

Top module: `cpu8_core`

## Requirements
- R1: While reset is held, imem_addr_o is 0 and neither dmem_we_o nor dmem_re_o is asserted. After reset, all eight registers and the four flags read as zero.
- R2: ADD (opcode 4, word bits [16:13]) writes (rA + rB) mod 256 to rA. Here rA is field [12:10] and rB is field [2:0]. ADD sets Z when the result is zero and OV on a carry out of bit 7.
- R3: CMPE (opcode 5) sets EQ to (rA == rB), and CMPL (opcode 6) sets LT to (rA < rB). Each flag holds its value until an instruction that writes that flag runs again.
- R4: SHF (opcode 7) shifts rA left by one with a zero fill. It sets OV to the bit shifted out and Z when the result is zero.
- R5: BRZ, BRE, BRL and BROV (opcodes 8 to 11) load the program counter from field [9:0] when Z, EQ, LT or OV is set, respectively. A taken branch discards every queued or in-flight word. A branch whose flag is clear falls through.
- R6: Opcode 2 loads the program counter with rA zero-extended to 10 bits. Opcode 3 writes the low 8 bits of its own instruction address to rA.
- R7: Opcode 0 loads rA from data address [9:0]. The next instruction sees the loaded value.
- R8: Opcode 12 stores rA to data address [9:0]. dmem_we_o is asserted in the cycle after the store executes. A later load from that address returns the stored value.
- R9: Instructions take effect in program order. The queue never holds more than four words, counting fetches in flight.
- R10: Opcodes 13 to 15 change no register, flag or memory. Opcode 1 copies rB into rA.
- R11: The data port never asserts read and write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_en_o | output | 1 | Instruction read request |
| imem_addr_o | output | 10 | Instruction address (fetch program counter) |
| imem_rdata_i | input | 17 | Instruction word, valid the cycle after the request |
| dmem_re_o | output | 1 | Data read request |
| dmem_we_o | output | 1 | Data write strobe |
| dmem_addr_o | output | 10 | Data address |
| dmem_wdata_o | output | 8 | Store data |
| dmem_rdata_i | input | 8 | Load data, valid the cycle after the read |

## Verification
The store stream is the observable result. Each dmem_we_o pulse comes exactly one cycle after its store executes, so the bench samples the data port on falling edges and matches pulses in order against a list that an instruction-level model of the program produces. A fetched word reaches execute two cycles after its request. A load needs two cycles, and a redirect costs three cycles before the next instruction runs. The bench therefore compares by store order rather than by fixed cycle, and it allows a cycle budget well above the worst case before it counts missing stores. Reset values are sampled while reset is still held.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;
  localparam int XLEN = 8;
  localparam int ALEN = 10;
  localparam int RIDX = 3;
  localparam int OPW  = 4;
  localparam int IW   = OPW + RIDX + ALEN;

  typedef logic [OPW-1:0] opcode_t;
  localparam opcode_t OP_LDM   = 4'd0;
  localparam opcode_t OP_MOV   = 4'd1;
  localparam opcode_t OP_JMPR  = 4'd2;
  localparam opcode_t OP_GETPC = 4'd3;
  localparam opcode_t OP_ADD   = 4'd4;
  localparam opcode_t OP_CMPE  = 4'd5;
  localparam opcode_t OP_CMPL  = 4'd6;
  localparam opcode_t OP_SHF   = 4'd7;
  localparam opcode_t OP_BRZ   = 4'd8;
  localparam opcode_t OP_BRE   = 4'd9;
  localparam opcode_t OP_BRL   = 4'd10;
  localparam opcode_t OP_BROV  = 4'd11;
  localparam opcode_t OP_ST    = 4'd12;

  typedef struct packed {
    logic z;
    logic ov;
    logic eq;
    logic lt;
  } flags_t;
endpackage

// File: rtl/cpu8_ifq.sv
module cpu8_ifq #(
  parameter int DEPTH = 4,
  parameter int IW    = 17,
  parameter int AW    = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic [AW-1:0] flush_pc_i,
  input  logic          pop_i,
  output logic          imem_en_o,
  output logic [AW-1:0] imem_addr_o,
  input  logic [IW-1:0] imem_rdata_i,
  output logic          head_vld_o,
  output logic [IW-1:0] head_word_o,
  output logic [AW-1:0] head_pc_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] pc_q, req_pc_q;
  logic          req_q;
  logic [CW-1:0] count_q;
  logic [PW-1:0] rd_ptr_q, wr_ptr_q;
  logic [IW-1:0] word_q [DEPTH];
  logic [AW-1:0] addr_q [DEPTH];
  logic          issue, push, pop;

  // in-flight fetch reserves a slot
  assign issue = !flush_i && ((count_q + CW'(req_q)) < CW'(DEPTH));
  assign push  = req_q && !flush_i;
  assign pop   = pop_i;

  assign imem_en_o   = issue;
  assign imem_addr_o = pc_q;
  assign head_vld_o  = (count_q != '0);
  assign head_word_o = word_q[rd_ptr_q];
  assign head_pc_o   = addr_q[rd_ptr_q];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      req_pc_q <= '0;
      req_q    <= 1'b0;
      count_q  <= '0;
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        word_q[i] <= '0;
        addr_q[i] <= '0;
      end
    end else if (flush_i) begin
      pc_q     <= flush_pc_i;
      req_q    <= 1'b0;
      count_q  <= '0;
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
    end else begin
      req_q    <= issue;
      req_pc_q <= pc_q;
      if (issue) pc_q <= pc_q + 1'b1;
      if (push) begin
        word_q[wr_ptr_q] <= imem_rdata_i;
        addr_q[wr_ptr_q] <= req_pc_q;
        wr_ptr_q         <= nxt(wr_ptr_q);
      end
      if (pop) rd_ptr_q <= nxt(rd_ptr_q);
      count_q <= count_q + CW'(push) - CW'(pop);
    end
  end

  AST_Q_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && !pop) |-> (count_q < CW'(DEPTH))); // R9
  AST_Q_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop |-> (count_q != '0)); // R9
  AST_Q_FLUSHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!head_vld_o && !req_q)); // R5
endmodule

// File: rtl/cpu8_rf.sv
module cpu8_rf #(
  parameter int NREG = 8,
  parameter int XLEN = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [RW-1:0]   ra_idx_i,
  input  logic [RW-1:0]   rb_idx_i,
  output logic [XLEN-1:0] ra_o,
  output logic [XLEN-1:0] rb_o,
  input  logic            we_i,
  input  logic [RW-1:0]   w_idx_i,
  input  logic [XLEN-1:0] w_data_i
);
  logic [XLEN-1:0] regs_q [NREG];

  assign ra_o = regs_q[ra_idx_i];
  assign rb_o = regs_q[rb_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[w_idx_i] <= w_data_i;
    end
  end
endmodule

// File: rtl/cpu8_alu.sv
module cpu8_alu #(
  parameter int XLEN = 8
) (
  input  logic            shift_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o,
  output logic            z_o,
  output logic            ov_o,
  output logic            eq_o,
  output logic            lt_o
);
  logic [XLEN:0] wide;

  always_comb begin
    if (shift_i) wide = {a_i, 1'b0};
    else         wide = {1'b0, a_i} + {1'b0, b_i};
  end

  assign res_o = wide[XLEN-1:0];
  assign ov_o  = wide[XLEN];
  assign z_o   = (res_o == '0);
  assign eq_o  = (a_i == b_i);
  assign lt_o  = (a_i < b_i);
endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
  import cpu8_pkg::*;
#(
  parameter int QDEPTH = 4,
  parameter int NREG   = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic            imem_en_o,
  output logic [ALEN-1:0] imem_addr_o,
  input  logic [IW-1:0]   imem_rdata_i,
  output logic            dmem_re_o,
  output logic            dmem_we_o,
  output logic [ALEN-1:0] dmem_addr_o,
  output logic [XLEN-1:0] dmem_wdata_o,
  input  logic [XLEN-1:0] dmem_rdata_i
);
  localparam int RW = $clog2(NREG);

  logic            head_vld;
  logic [IW-1:0]   head_word;
  logic [ALEN-1:0] head_pc;
  opcode_t         op;
  logic [RW-1:0]   ra_idx, rb_idx;
  logic [ALEN-1:0] fld;
  logic [XLEN-1:0] ra, rb, alu_res;
  logic            alu_z, alu_ov, alu_eq, alu_lt;
  flags_t          flags_q;
  logic            exec_ok, taken, redirect, st_fire, ld_fire;
  logic [ALEN-1:0] redirect_pc;
  logic            rf_we;
  logic [RW-1:0]   rf_widx;
  logic [XLEN-1:0] rf_wdata;
  logic            ld_pend_q, wr_pend_q;
  logic [RW-1:0]   ld_rd_q;
  logic [ALEN-1:0] wir_q;
  logic [XLEN-1:0] wres_q;

  assign op     = head_word[IW-1 -: OPW];
  assign ra_idx = head_word[ALEN +: RW];
  assign fld    = head_word[ALEN-1:0];
  assign rb_idx = fld[RW-1:0];

  cpu8_ifq #(.DEPTH(QDEPTH), .IW(IW), .AW(ALEN)) u_ifq (
    .clk_i, .rst_ni,
    .flush_i(redirect), .flush_pc_i(redirect_pc), .pop_i(exec_ok),
    .imem_en_o, .imem_addr_o, .imem_rdata_i,
    .head_vld_o(head_vld), .head_word_o(head_word), .head_pc_o(head_pc)
  );

  cpu8_rf #(.NREG(NREG), .XLEN(XLEN)) u_rf (
    .clk_i, .rst_ni,
    .ra_idx_i(ra_idx), .rb_idx_i(rb_idx), .ra_o(ra), .rb_o(rb),
    .we_i(rf_we), .w_idx_i(rf_widx), .w_data_i(rf_wdata)
  );

  cpu8_alu #(.XLEN(XLEN)) u_alu (
    .shift_i(op == OP_SHF), .a_i(ra), .b_i(rb), .res_o(alu_res),
    .z_o(alu_z), .ov_o(alu_ov), .eq_o(alu_eq), .lt_o(alu_lt)
  );

  // load data return and store-port conflicts both hold execute
  assign exec_ok = head_vld && !ld_pend_q && !(op == OP_LDM && wr_pend_q);
  assign st_fire = exec_ok && (op == OP_ST);
  assign ld_fire = exec_ok && (op == OP_LDM);

  always_comb begin
    case (op)
      OP_BRZ:  taken = flags_q.z;
      OP_BRE:  taken = flags_q.eq;
      OP_BRL:  taken = flags_q.lt;
      OP_BROV: taken = flags_q.ov;
      OP_JMPR: taken = 1'b1;
      default: taken = 1'b0;
    endcase
  end
  assign redirect    = exec_ok && taken;
  assign redirect_pc = (op == OP_JMPR) ? ALEN'(ra) : fld;

  always_comb begin
    rf_we    = 1'b0;
    rf_widx  = ra_idx;
    rf_wdata = alu_res;
    if (ld_pend_q) begin
      rf_we    = 1'b1;
      rf_widx  = ld_rd_q;
      rf_wdata = dmem_rdata_i;
    end else if (exec_ok) begin
      case (op)
        OP_MOV:         begin rf_we = 1'b1; rf_wdata = rb; end
        OP_GETPC:       begin rf_we = 1'b1; rf_wdata = head_pc[XLEN-1:0]; end
        OP_ADD, OP_SHF: rf_we = 1'b1;
        default:        rf_we = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q   <= '0;
      ld_pend_q <= 1'b0;
      ld_rd_q   <= '0;
      wr_pend_q <= 1'b0;
      wir_q     <= '0;
      wres_q    <= '0;
    end else begin
      ld_pend_q <= ld_fire;
      if (ld_fire) ld_rd_q <= ra_idx;
      wr_pend_q <= st_fire;
      if (st_fire) begin
        wir_q  <= fld;
        wres_q <= ra;
      end
      if (exec_ok) begin
        case (op)
          OP_ADD, OP_SHF: begin flags_q.z <= alu_z; flags_q.ov <= alu_ov; end
          OP_CMPE:        flags_q.eq <= alu_eq;
          OP_CMPL:        flags_q.lt <= alu_lt;
          default: ;
        endcase
      end
    end
  end

  assign dmem_re_o    = ld_fire;
  assign dmem_we_o    = wr_pend_q;
  assign dmem_addr_o  = wr_pend_q ? wir_q : fld;
  assign dmem_wdata_o = wres_q;

  AST_DMEM_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dmem_re_o && dmem_we_o)); // R11
  AST_STORE_RETIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_fire |=> (dmem_we_o && dmem_addr_o == $past(fld) && dmem_wdata_o == $past(ra))); // R8
  AST_LOAD_HOLDS_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_pend_q |-> !exec_ok); // R7
  AST_LOAD_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_fire |=> rf_we); // R7
  AST_FLAGS_STABLE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_ok |=> $stable(flags_q)); // R3
endmodule

// File: tb/cpu8_core_tb_top.sv
module cpu8_core_tb_top;
  localparam int IW = 17;
  localparam int MAXST = 512;
  localparam int PLEN = 48;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic imem_en, dmem_re, dmem_we;
  logic [9:0] imem_addr, dmem_addr;
  logic [IW-1:0] imem_rdata;
  logic [7:0] dmem_wdata, dmem_rdata;

  always #2 clk = ~clk;

  cpu8_core dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .imem_en_o(imem_en), .imem_addr_o(imem_addr), .imem_rdata_i(imem_rdata),
    .dmem_re_o(dmem_re), .dmem_we_o(dmem_we), .dmem_addr_o(dmem_addr),
    .dmem_wdata_o(dmem_wdata), .dmem_rdata_i(dmem_rdata)
  );

  logic [IW-1:0] imem [1024];
  logic [7:0] dmem [1024];
  logic [7:0] mdm [1024];
  logic [9:0] exp_a [MAXST];
  logic [7:0] exp_d [MAXST];
  int exp_n, got_n, collisions;
  int n_checks = 0, n_fail = 0, cycles = 0;
  bit monitor_on = 0;
  string cur_tag = "R9";

  always_ff @(posedge clk) begin
    if (imem_en) imem_rdata <= imem[imem_addr];
    if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
    if (dmem_re) dmem_rdata <= dmem[dmem_addr];
  end

  always @(posedge clk) cycles++;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (monitor_on && rst_ni) begin
      if (dmem_we && dmem_re) collisions++;
      if (dmem_we) begin
        if (got_n < exp_n) begin
          check(dmem_addr == exp_a[got_n], cur_tag, "store address", dmem_addr, exp_a[got_n]);
          check(dmem_wdata == exp_d[got_n], cur_tag, "store data", dmem_wdata, exp_d[got_n]);
        end
        got_n++;
      end
    end
  end

  function automatic logic [IW-1:0] enc(input int op, input int r, input int f);
    return {op[3:0], r[2:0], f[9:0]};
  endfunction

  // instruction-level reference
  task automatic model_run(input int steps);
    logic [7:0] rg [8];
    logic z, ov, eq, lt;
    logic [9:0] pc;
    logic [8:0] w;
    z = 0; ov = 0; eq = 0; lt = 0; pc = '0; exp_n = 0;
    for (int i = 0; i < 8; i++) rg[i] = '0;
    for (int s = 0; s < steps; s++) begin
      logic [IW-1:0] iw;
      logic [3:0] op;
      logic [2:0] a, b;
      logic [9:0] f, npc;
      iw = imem[pc]; op = iw[16:13]; a = iw[12:10]; f = iw[9:0]; b = f[2:0];
      npc = pc + 10'd1;
      case (op)
        0: rg[a] = mdm[f];
        1: rg[a] = rg[b];
        2: npc = {2'b00, rg[a]};
        3: rg[a] = pc[7:0];
        4: begin w = {1'b0, rg[a]} + {1'b0, rg[b]}; rg[a] = w[7:0]; ov = w[8]; z = (w[7:0] == 0); end
        5: eq = (rg[a] == rg[b]);
        6: lt = (rg[a] < rg[b]);
        7: begin w = {rg[a], 1'b0}; rg[a] = w[7:0]; ov = w[8]; z = (w[7:0] == 0); end
        8: if (z) npc = f;
        9: if (eq) npc = f;
        10: if (lt) npc = f;
        11: if (ov) npc = f;
        12: begin
          mdm[f] = rg[a];
          if (exp_n < MAXST) begin exp_a[exp_n] = f; exp_d[exp_n] = rg[a]; exp_n++; end
        end
        default: ;
      endcase
      pc = npc;
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) begin
      imem[i] = enc(15, 0, 0);
      dmem[i] = 8'($urandom_range(0, 255));
      mdm[i] = dmem[i];
    end
  endtask

  task automatic run_dut(input int ncyc, input string tag);
    @(negedge clk);
    rst_ni = 1'b0;
    got_n = 0; collisions = 0; cur_tag = tag;
    repeat (2) @(negedge clk);
    check(imem_addr == 10'd0, "R1", "imem address in reset", imem_addr, 0);
    check(!dmem_we && !dmem_re, "R1", "data port idle in reset", {dmem_we, dmem_re}, 0);
    rst_ni = 1'b1;
    monitor_on = 1;
    repeat (ncyc) @(negedge clk);
    monitor_on = 0;
    check(got_n >= exp_n, tag, "store count", got_n, exp_n);
    check(collisions == 0, "R11", "read and write together", collisions, 0);
  endtask

  task automatic directed();
    int ea [8] = '{32, 34, 36, 37, 38, 39, 41, 42};
    int ed [8] = '{44, 200, 11, 11, 0, 44, 21, 44};
    clear_mem();
    dmem[16] = 200; dmem[17] = 100; dmem[18] = 21;
    mdm[16] = 200; mdm[17] = 100; mdm[18] = 21;
    imem[0]  = enc(0, 1, 16);
    imem[1]  = enc(0, 2, 17);
    imem[2]  = enc(4, 1, 2);   // 200+100 -> 44, OV
    imem[3]  = enc(12, 1, 32);
    imem[4]  = enc(11, 0, 6);  // BROV taken
    imem[5]  = enc(12, 1, 33);
    imem[6]  = enc(7, 2, 0);   // 100<<1 = 200
    imem[7]  = enc(12, 2, 34);
    imem[8]  = enc(6, 1, 2);   // 44<200
    imem[9]  = enc(10, 0, 11);
    imem[10] = enc(12, 2, 35);
    imem[11] = enc(3, 3, 0);   // own address 11
    imem[12] = enc(12, 3, 36);
    imem[13] = enc(13, 3, 0);  // no-op
    imem[14] = enc(12, 3, 37);
    imem[15] = enc(12, 4, 38); // never written
    imem[16] = enc(0, 5, 32);  // load right after store stream
    imem[17] = enc(12, 5, 39);
    imem[18] = enc(0, 6, 18);
    imem[19] = enc(2, 6, 0);   // jump to 21
    imem[20] = enc(12, 6, 40);
    imem[21] = enc(12, 6, 41);
    imem[22] = enc(8, 0, 0);   // Z clear, falls through
    imem[23] = enc(12, 1, 42);
    for (int i = 0; i < 8; i++) begin exp_a[i] = 10'(ea[i]); exp_d[i] = 8'(ed[i]); end
    exp_n = 8;
    // R2 R4 R5 R6 R7 R8 R10 R1: hand-computed store stream
    run_dut(200, "R2/R4/R5/R6/R7/R8/R10");
  endtask

  function automatic logic [IW-1:0] rnd_instr();
    int op = $urandom_range(0, 15);
    int r = $urandom_range(0, 7);
    case (op)
      0, 12: return enc(op, r, $urandom_range(0, 15));
      2: return ($urandom_range(0, 3) == 0) ? enc(op, r, 0) : enc(15, r, 0);
      8, 9, 10, 11: return enc(op, r, $urandom_range(0, PLEN - 1));
      default: return enc(op, r, $urandom_range(0, 7));
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    directed();
    // R3 R9 R10: random programs against the reference
    for (int p = 0; p < 14; p++) begin
      clear_mem();
      for (int i = 0; i < PLEN; i++) imem[i] = rnd_instr();
      model_run(400);
      run_dut(3000, (p % 2) ? "R3" : "R9");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    wait (cycles > 190000);
    n_checks++; n_fail++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", cycles, 190000);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule